// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Sequencer

This block times each switching cycle of a valley-switched flyback converter. It drives one gate-enable output and runs from a fixed reference clock. Its inputs are digital flags from external comparators: a current-limit trip, a valley detect and an enable. It also takes a programmable minimum off-time, given in clock ticks.

An on-period ends on one of two events. The first is a current-limit trip that arrives after a turn-on blanking window. The second is a maximum on-time. After turn-off the gate stays low for the longer of two intervals: the minimum off-time, or a fixed ringing-blanking window. Only then is valley detection armed. The first valley seen while armed starts a short turn-on delay, after which the gate rises. If no valley arrives within a timeout, a new cycle starts anyway. The block marks the event that ended each on-period, and the event that started each new one, with one-cycle status pulses.

All windows are parameters expressed in clock ticks. At the default 8 ns tick they are:

| Window | Ticks | Time |
|---|---|---|
| Turn-on blanking | 78 | about 625 ns |
| Maximum on-time | 5625 | 45 µs |
| Ringing blanking | 500 | 4 µs |
| Valley timeout | 1125 | 9 µs |
| Turn-on delay | 25 | 200 ns |

Top module: `qr_cycle_seq`

## Requirements
- R1: During the first BLANK_ON cycles of an on-period the current-limit input has no effect: a trip sampled in on-cycle j < BLANK_ON leaves the on-period running to MAX_ON cycles.
- R2: A current-limit trip sampled in on-cycle j >= BLANK_ON (cycles counted from 0) ends the on-period after exactly j+1 cycles, and `end_ilim` pulses in the first low cycle.
- R3: Without a trip, the gate stays high for exactly MAX_ON cycles, and `end_maxon` pulses in the first low cycle.
- R4: After every falling edge of the gate there is an off window of A = max(`toff_min`, OFF_BLANK) cycles. During this window valley inputs are discarded, and they are not remembered afterwards.
- R5: A valley sampled in low-cycle v, with A <= v < A+TIMEOUT, makes the gate rise in low-cycle v+1+VALLEY_DLY, so the low time is v+1+VALLEY_DLY cycles. `start_valley` pulses once during that low period.
- R6: If no valley is accepted, the gate rises after A+TIMEOUT low cycles, and `start_timeout` pulses in the first high cycle.
- R7: When `en` is low at a clock edge, the gate is low in the following cycle and the sequencer is idle. Valleys and trips have no effect while it is idle. The first cycle with `en` high again begins a fresh off window.
- R8: The four status outputs are single-cycle pulses, and at most one of them is high in any cycle.
- R9: After reset the gate and all status outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces idle |
| ilim | input | 1 | Current-limit comparator flag |
| valley | input | 1 | Valley detect flag |
| toff_min | input | CW | Minimum off-time in ticks |
| gate | output | 1 | Gate enable |
| end_ilim | output | 1 | Pulse: on-period ended by current limit |
| end_maxon | output | 1 | Pulse: on-period ended by maximum on-time |
| start_valley | output | 1 | Pulse: next cycle started by a valley |
| start_timeout | output | 1 | Pulse: next cycle started by timeout |

## Verification
The assertions check properties that hold on every cycle:
- Disabling the sequencer drops the gate on the next cycle.
- No current-limit trip ends a pulse inside the turn-on blanking window.
- Every falling edge carries an end-cause pulse.
- Every rising edge is preceded by either the turn-on delay or a timeout.
- The status pulses are mutually exclusive.

The exact cycle counts can only be shown by the bench's sweeps. These cover the on-time for every trip position, the low time for every valley position across a range of minimum off-time values, and a fresh restart after loss of enable.

// File: rtl/qr_cycle_seq.sv
`timescale 1ns/1ps
module qr_cycle_seq #(
  parameter int CW         = 16,
  parameter int BLANK_ON   = 78,
  parameter int MAX_ON     = 5625,
  parameter int OFF_BLANK  = 500,
  parameter int TIMEOUT    = 1125,
  parameter int VALLEY_DLY = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ilim,
  input  logic          valley,
  input  logic [CW-1:0] toff_min,
  output logic          gate,
  output logic          end_ilim,
  output logic          end_maxon,
  output logic          start_valley,
  output logic          start_timeout
);
  typedef enum logic [2:0] {S_IDLE, S_OFF, S_ARM, S_DLY, S_ON} st_t;

  localparam logic [CW-1:0] BLANK_C = CW'(BLANK_ON);
  localparam logic [CW-1:0] MAXON_C = CW'(MAX_ON - 1);
  localparam logic [CW-1:0] OFFBL_C = CW'(OFF_BLANK);
  localparam logic [CW-1:0] TOUT_C  = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] DLY_C   = CW'(VALLEY_DLY - 1);

  st_t           st, nxt;
  logic [CW-1:0] cnt;
  logic [CW:0]   arm_at;
  logic          p_ilim, p_max, p_val, p_tout;

  assign arm_at = (toff_min > OFFBL_C) ? {1'b0, toff_min} : {1'b0, OFFBL_C};
  assign gate   = (st == S_ON);

  always_comb begin
    nxt    = st;
    p_ilim = 1'b0;
    p_max  = 1'b0;
    p_val  = 1'b0;
    p_tout = 1'b0;
    if (!en) nxt = S_IDLE;
    else begin
      unique case (st)
        S_IDLE: nxt = S_OFF;
        S_OFF:  if ({1'b0, cnt} + 1'b1 >= arm_at) nxt = S_ARM;
        S_ARM:
          if (valley) begin
            nxt = S_DLY; p_val = 1'b1;
          end else if (cnt >= TOUT_C) begin
            nxt = S_ON; p_tout = 1'b1;
          end
        S_DLY:  if (cnt >= DLY_C) nxt = S_ON;
        S_ON:
          if (ilim && cnt >= BLANK_C) begin
            nxt = S_OFF; p_ilim = 1'b1;
          end else if (cnt >= MAXON_C) begin
            nxt = S_OFF; p_max = 1'b1;
          end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      cnt           <= '0;
      end_ilim      <= 1'b0;
      end_maxon     <= 1'b0;
      start_valley  <= 1'b0;
      start_timeout <= 1'b0;
    end else begin
      st            <= nxt;
      cnt           <= (nxt != st) ? '0 : cnt + 1'b1;
      end_ilim      <= p_ilim;
      end_maxon     <= p_max;
      start_valley  <= p_val;
      start_timeout <= p_tout;
    end
  end

  // R7
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !gate);
  // R1
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == S_ON && cnt < BLANK_C) |=> gate);
  // R2
  end_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate) && $past(en)) |-> (end_ilim || end_maxon));
  // R6
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> (start_timeout || $past(st) == S_DLY));
  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({end_ilim, end_maxon, start_valley, start_timeout}));
  // R5
  valley_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_valley |-> !gate);
endmodule

// File: tb/qr_cycle_seq_bench.sv
`timescale 1ns/1ps
module qr_cycle_seq_bench;
  localparam int CW = 16, B = 4, M = 20, OB = 6, TO = 10, VD = 3;

  logic clk = 0, rst_n = 0, en = 0, ilim = 0, valley = 0;
  logic [CW-1:0] toff_min = '0;
  logic gate, end_ilim, end_maxon, start_valley, start_timeout;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  qr_cycle_seq #(.CW(CW), .BLANK_ON(B), .MAX_ON(M), .OFF_BLANK(OB),
                 .TIMEOUT(TO), .VALLEY_DLY(VD)) u_qr_cycle_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .ilim(ilim), .valley(valley),
    .toff_min(toff_min), .gate(gate), .end_ilim(end_ilim),
    .end_maxon(end_maxon), .start_valley(start_valley),
    .start_timeout(start_timeout));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int arm_of(input int t);
    return (t > OB) ? t : OB;
  endfunction

  task automatic on_phase(input int at, output int len, output bit ei, output bit em);
    len = 0;
    while (gate && len < 1000) begin
      ilim = (len == at);
      len++;
      @(negedge clk);
    end
    ilim = 0;
    ei = end_ilim;
    em = end_maxon;
  endtask

  task automatic off_phase(input int mode, input int v, output int len,
                           output int nsv, output int nst);
    len = 0; nsv = 0; nst = 0;
    while (!gate && len < 1000) begin
      valley = (mode == 2) || (mode == 1 && len == v);
      nsv += int'(start_valley);
      nst += int'(start_timeout);
      len++;
      @(negedge clk);
    end
    valley = 0;
    nst += int'(start_timeout);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int len, nsv, nst, exp, a;
    bit ei, em;
    repeat (3) @(negedge clk);
    // R9
    chk(gate == 0 && {end_ilim, end_maxon, start_valley, start_timeout} == 0,
        "R9 reset outputs", int'(gate), 0);
    rst_n = 1;
    @(negedge clk);
    en = 1;
    @(negedge clk);

    // R4 R5: first low period from fresh start, valley held high
    off_phase(2, 0, len, nsv, nst);
    chk(len == OB + 1 + VD, "R5 fresh low time", len, OB + 1 + VD);

    // R1 R2 R3: sweep trip position over every on-cycle, plus no trip
    for (int j = 0; j <= M; j++) begin
      on_phase(j, len, ei, em);
      exp = (j >= B && j < M) ? j + 1 : M;
      if (j < B) chk(len == exp, "R1 trip in blanking ignored", len, exp);
      else if (j < M) chk(len == exp && ei && !em, "R2 trip ends pulse", len, exp);
      else chk(len == exp && em && !ei, "R3 max on-time", len, exp);
      off_phase(2, 0, len, nsv, nst);
      chk(len == OB + 1 + VD && nsv == 1 && nst == 0, "R5 valley restart", len, OB + 1 + VD);
    end

    // R4 R5 R6: sweep min off-time and valley position
    for (int t = 0; t <= 12; t++) begin
      a = arm_of(t);
      for (int v = 0; v < a + TO + 2; v++) begin
        toff_min = CW'(t);
        on_phase(-1, len, ei, em);
        off_phase(1, v, len, nsv, nst);
        if (v >= a && v < a + TO) begin
          exp = v + 1 + VD;
          chk(len == exp && nsv == 1 && nst == 0, "R5 accepted valley", len, exp);
        end else begin
          exp = a + TO;
          if (v < a) chk(len == exp && nsv == 0 && nst == 1, "R4 early valley discarded", len, exp);
          else chk(len == exp && nsv == 0 && nst == 1, "R6 timeout restart", len, exp);
        end
      end
    end

    // R6: no valley at all
    toff_min = CW'(9);
    on_phase(-1, len, ei, em);
    off_phase(0, 0, len, nsv, nst);
    chk(len == 9 + TO && nst == 1, "R6 timeout no valley", len, 9 + TO);

    // R7: drop enable mid on-period
    toff_min = '0;
    repeat (5) @(negedge clk);
    chk(gate == 1, "R7 precondition gate high", int'(gate), 1);
    en = 0;
    @(negedge clk);
    chk(gate == 0, "R7 gate low after disable", int'(gate), 0);
    valley = 1; ilim = 1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk(gate == 0 && !start_valley && !start_timeout, "R7 idle ignores inputs", int'(gate), 0);
    end
    valley = 0; ilim = 0;
    en = 1;
    @(negedge clk);
    off_phase(2, 0, len, nsv, nst);
    chk(len == OB + 1 + VD, "R7 fresh off after re-enable", len, OB + 1 + VD);
    on_phase(-1, len, ei, em);
    chk(len == M && em, "R3 on after re-enable", len, M);

    // R8: pulses last one cycle
    @(negedge clk);
    chk(!end_maxon, "R8 single-cycle pulse", int'(end_maxon), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule